// File: doc/BRIEF.md
# Three-Digit Decimal Seven-Segment Driver

This block takes an unsigned 8-bit value and shows it in decimal on three multiplexed common-cathode seven-segment digits. A value is captured only in a clock cycle where the display strobe is high. Between strobes the captured value holds, whatever the data input does.

The captured value is split into hundreds, tens and ones by constant division and remainder. The digit being scanned is then turned into a segment pattern by a pattern lookup. The lookup index joins a digit-place region with the decimal digit. The fourth region is reserved and always returns dark segments. A refresh tick, separate from the processor's instruction rate, steps the scan through four slots: ones, tens, hundreds and a dark slot. Each slot has its own one-hot digit enable.

Top module: `dec7seg_driver`

## Requirements
- R1: While reset is held and after it is released, the captured value is 0. The scan sits on the ones slot with `dig_en` = 4'b0001, and `seg` shows the pattern for 0 (0x7E).
- R2: On a rising clock edge with `show_stb` high, `show_val` is captured. The segments reflect it from that edge onward.
- R3: On an edge with `show_stb` low, the captured value is unchanged. Changing `show_val` has no effect on `seg` in any slot.
- R4: The ones slot shows value mod 10, the tens slot shows (value/10) mod 10, and the hundreds slot shows value/100. Leading zeros are shown.
- R5: `seg` is {a,b,c,d,e,f,g} with segment a in bit 6. Digits 0 to 9 encode as 0x7E, 0x30, 0x6D, 0x79, 0x33, 0x5B, 0x5F, 0x70, 0x7F and 0x7B.
- R6: Each edge with `scan_tick` high moves the scan one slot. The slot order is ones (`dig_en` bit 0), tens (bit 1), hundreds (bit 2), dark (bit 3), then back to ones.
- R7: On an edge with `scan_tick` low, `dig_en` is unchanged.
- R8: Exactly one bit of `dig_en` is high at all times.
- R9: In the dark slot (`dig_en` = 4'b1000), `seg` is 0.
- R10: Once 142 is captured, the hundreds slot shows 0x30, the tens slot shows 0x33 and the ones slot shows 0x6D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| show_stb | input | 1 | Capture strobe for `show_val` |
| show_val | input | 8 | Value to display |
| scan_tick | input | 1 | Refresh tick, one clock wide, advances the scan slot |
| seg | output | 7 | Segment bus, a in bit 6 through g in bit 0, active high |
| dig_en | output | 4 | One-hot digit enable: ones, tens, hundreds, dark |

## Verification
The bench builds the block with its default 8-bit value width, so the full input range is only 256 values. That makes a complete sweep cheap. Every value is captured and all four scan slots are observed, which covers each digit in each place, every carry into tens and hundreds, and the maximum, 255. Hold behaviour is checked by moving `show_val` and idling `scan_tick` between strobes and ticks, then reading the segments and enables through the normal scan.

// File: rtl/dec7seg_pkg.sv
// Package: shared types and segment encoding for the decimal display driver.
// Assumes segment order {a,b,c,d,e,f,g} with a in the most significant bit.
package dec7seg_pkg;

    localparam int SEG_W  = 7;
    localparam int NPLACE = 3;
    localparam int NSLOT  = NPLACE + 1;

    typedef enum logic [1:0] {
        SLOT_ONES = 2'd0,
        SLOT_TENS = 2'd1,
        SLOT_HUND = 2'd2,
        SLOT_DARK = 2'd3
    } slot_e;

    // Map one decimal digit to its lit segments; non-decimal codes are dark.
    function automatic logic [SEG_W-1:0] digit_pattern(input logic [3:0] d);
        logic [SEG_W-1:0] p;
        case (d)
            4'd0:    p = 7'h7E;
            4'd1:    p = 7'h30;
            4'd2:    p = 7'h6D;
            4'd3:    p = 7'h79;
            4'd4:    p = 7'h33;
            4'd5:    p = 7'h5B;
            4'd6:    p = 7'h5F;
            4'd7:    p = 7'h70;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h7B;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dec7seg_split.sv
// Module: splits an unsigned value into decimal digits, one per place.
// Assumes VAL_W is small enough that value/10**(NPLACE-1) fits in one digit
// (true for the default 8-bit width with three places).
module dec7seg_split #(
    parameter int VAL_W  = 8,
    parameter int NPLACE = 3
) (
    input  logic [VAL_W-1:0]         val,
    output logic [NPLACE-1:0][3:0]   digits
);

    generate
        for (genvar p = 0; p < NPLACE; p++) begin : g_place
            localparam int DIV = 10 ** p;
            logic [VAL_W-1:0] scaled;
            // Shift the place of interest down to the units position.
            assign scaled    = val / VAL_W'(DIV);
            // Keep only the units digit of the shifted value.
            assign digits[p] = 4'(scaled % VAL_W'(10));
        end
    endgenerate

endmodule

// File: rtl/dec7seg_rom.sv
// Module: segment pattern lookup indexed by {place region, digit}.
// Regions below the reserved one return the digit's pattern; the reserved
// top region always returns dark segments.
module dec7seg_rom
    import dec7seg_pkg::*;
#(
    parameter int REGION_W = 2,
    parameter int INDEX_W  = 8
) (
    input  logic [REGION_W-1:0] region,
    input  logic [INDEX_W-1:0]  index,
    output logic [SEG_W-1:0]    pattern
);

    localparam logic [REGION_W-1:0] DARK_REGION = {REGION_W{1'b1}};

    logic [REGION_W+INDEX_W-1:0] addr;
    assign addr = {region, index};

    // Decode the flat address into region and digit, then pick a pattern.
    always_comb begin
        if (addr[REGION_W+INDEX_W-1 -: REGION_W] == DARK_REGION) begin
            pattern = '0;
        end else if (addr[INDEX_W-1:0] > INDEX_W'(9)) begin
            pattern = '0;
        end else begin
            pattern = digit_pattern(addr[3:0]);
        end
    end

endmodule

// File: rtl/dec7seg_scan.sv
// Module: refresh scanner; steps through ones, tens, hundreds and a dark slot
// on each refresh tick and drives a one-hot digit enable.
// Assumes scan_tick is a single-clock pulse synchronous to clk.
module dec7seg_scan
    import dec7seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    output slot_e            slot,
    output logic [NSLOT-1:0] dig_en
);

    // Advance the slot on a tick, wrapping after the dark slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= SLOT_ONES;
        end else if (scan_tick) begin
            slot <= slot_e'(slot + 2'd1);
        end
    end

    // Decode the active slot into a one-hot enable.
    always_comb begin
        dig_en = '0;
        dig_en[slot] = 1'b1;
    end

    // R8: only one digit is enabled at a time
    p_onehot_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dig_en) == 1);

    // R6: a tick rotates the enable one place toward higher bits
    p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick |=> (dig_en == {$past(dig_en[NSLOT-2:0]), $past(dig_en[NSLOT-1])}));

    // R7: no tick, no movement
    p_hold_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(dig_en));

endmodule

// File: rtl/dec7seg_driver.sv
// Module: top of the three-digit decimal seven-segment driver.
// Captures show_val on show_stb, splits it into decimal places, and drives
// the pattern for the scanned place onto the segment bus.
module dec7seg_driver
    import dec7seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             show_stb,
    input  logic [7:0]       show_val,
    input  logic             scan_tick,
    output logic [6:0]       seg,
    output logic [3:0]       dig_en
);

    localparam int VAL_W = 8;

    logic [VAL_W-1:0]        val_q;
    logic [NPLACE-1:0][3:0]  digits;
    slot_e                   slot;
    logic [3:0]              cur_digit;

    // Capture the value to display on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (show_stb) begin
            val_q <= show_val;
        end
    end

    dec7seg_split #(
        .VAL_W  (VAL_W),
        .NPLACE (NPLACE)
    ) u_split (
        .val    (val_q),
        .digits (digits)
    );

    dec7seg_scan u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .slot      (slot),
        .dig_en    (dig_en)
    );

    // Select the decimal digit belonging to the scanned place.
    always_comb begin
        case (slot)
            SLOT_ONES: cur_digit = digits[0];
            SLOT_TENS: cur_digit = digits[1];
            SLOT_HUND: cur_digit = digits[2];
            default:   cur_digit = 4'd0;
        endcase
    end

    dec7seg_rom #(
        .REGION_W (2),
        .INDEX_W  (8)
    ) u_rom (
        .region  (slot),
        .index   ({4'd0, cur_digit}),
        .pattern (seg)
    );

    // R2: a strobe loads the presented value
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        show_stb |=> (val_q == $past(show_val)));

    // R3: without a strobe the captured value holds
    p_hold_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !show_stb |=> $stable(val_q));

    // R9: the dark slot lights nothing
    p_dark_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dig_en[3] |-> (seg == 7'h00));

endmodule

// File: tb/sim_dec7seg_driver.sv
module sim_dec7seg_driver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       show_stb = 1'b0;
    logic [7:0] show_val = 8'h00;
    logic       scan_tick = 1'b0;
    logic [6:0] seg;
    logic [3:0] dig_en;

    int checks = 0;
    int errors = 0;
    int exp_slot = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dec7seg_driver u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .show_stb  (show_stb),
        .show_val  (show_val),
        .scan_tick (scan_tick),
        .seg       (seg),
        .dig_en    (dig_en)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h7E; 1: return 7'h30; 2: return 7'h6D; 3: return 7'h79;
            4: return 7'h33; 5: return 7'h5B; 6: return 7'h5F; 7: return 7'h70;
            8: return 7'h7F; 9: return 7'h7B;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [6:0] exp_seg(input int v, input int s);
        case (s)
            0: return pat(v % 10);
            1: return pat((v / 10) % 10);
            2: return pat(v / 100);
            default: return 7'h00;
        endcase
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, settle after the rising edge.
    task automatic cyc(input logic stb, input logic [7:0] v, input logic tk);
        @(negedge clk);
        show_stb  = stb;
        show_val  = v;
        scan_tick = tk;
        @(posedge clk);
        #2;
        show_stb  = 1'b0;
        scan_tick = 1'b0;
        if (tk) exp_slot = (exp_slot + 1) % 4;
    endtask

    task automatic chk_slot(input string req, input int v);
        chk({req, " en"}, dig_en, 1 << exp_slot);
        chk({req, " seg"}, seg, exp_seg(v, exp_slot));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) cyc(1'b1, 8'hA5, 1'b1);
        exp_slot = 0;
        chk("R1 en in reset", dig_en, 4'b0001);
        chk("R1 seg in reset", seg, 7'h7E);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 8'h00, 1'b0);
        chk("R1 en after reset", dig_en, 4'b0001);
        chk("R1 seg after reset", seg, 7'h7E);

        // R2 R4 R5 R6 R8 R9: full sweep over every value and slot
        for (int v = 0; v < 256; v++) begin
            cyc(1'b1, 8'(v), 1'b0);
            for (int k = 0; k < 4; k++) begin
                chk_slot("R2 R4 R5 R6 R8 R9 sweep", v);
                cyc(1'b0, 8'(v), 1'b1);
            end
        end

        // R10: value 142 by place
        cyc(1'b1, 8'd142, 1'b0);
        while (exp_slot != 0) cyc(1'b0, 8'd0, 1'b1);
        chk("R10 ones", seg, 7'h6D);
        cyc(1'b0, 8'd0, 1'b1);
        chk("R10 tens", seg, 7'h33);
        cyc(1'b0, 8'd0, 1'b1);
        chk("R10 hundreds", seg, 7'h30);
        cyc(1'b0, 8'd0, 1'b1);
        chk("R9 dark seg", seg, 7'h00);
        chk("R6 dark en", dig_en, 4'b1000);
        cyc(1'b0, 8'd0, 1'b1);
        chk("R6 wrap to ones", dig_en, 4'b0001);

        // R3: data changes without a strobe leave every slot showing 142
        for (int k = 0; k < 4; k++) begin
            cyc(1'b0, 8'(8'h55 + k * 37), 1'b0);
            cyc(1'b0, 8'(8'hC3 - k), 1'b0);
            chk_slot("R3 hold value", 142);
            cyc(1'b0, 8'd7, 1'b1);
        end

        // R7: idle cycles without a tick keep the enable in place
        cyc(1'b0, 8'd0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 8'd0, 1'b0);
            chk("R7 no tick", dig_en, 1 << exp_slot);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule